// File: doc/BRIEF.md
# IDE Channel Interrupt Status Mirror

This block is a configuration-register slice for a two-channel disk controller. Each channel has one interrupt-pending flag. Software can see that flag in two places: a per-channel status byte and a shared mode byte that also holds a mask ("block") bit for each channel. The block keeps the two views equal at all times. It folds the unmasked pending flags into one level-sensitive interrupt line.

Each channel's request line is a level. The flag follows the line whenever the line changes. Between changes, software clears the flag by writing a one to either view, and the other view updates with it. Configuration writes arrive as an aligned word of byte lanes with byte enables. Reads return an aligned word from a combinational path. The mask bits are not writable through the configuration port. They are loaded through a separate narrow port owned by the data-transfer engine. A read-only enable byte reports which channels exist.

Top module: `irq_status_mirror`

## Requirements
- R1: After reset, every pending flag and mask bit is 0 and `irq_out` is 0. The word at 0x50 reads 0x0000_0C00 with SECONDARY_EN=1. The words at 0x54 and 0x70 read 0.
- R2: Byte 0x51 is read-only. Bit 2 is always 1. Bit 3 equals SECONDARY_EN. All other bits are 0, and configuration writes never change it.
- R3: A change on `chan_irq[c]` sets the channel-c flag to the new level. The flag is visible in both views: channel 0 at byte 0x50 bit 2 and byte 0x71 bit 2; channel 1 at byte 0x57 bit 4 and byte 0x71 bit 3. The two views are always equal.
- R4: A configuration write with byte 0x71 enabled clears each flag whose bit (2 or 3) is written as 1. The matching status-byte view clears too. Writing 0 leaves the flag unchanged.
- R5: A configuration write of 1 to byte 0x50 bit 2 or byte 0x57 bit 4 clears that channel's flag in both views.
- R6: Mask bits 4 and 5 of byte 0x71, and every non-flag bit of bytes 0x50, 0x57 and 0x71, are unchanged by configuration writes.
- R7: A byte lane whose enable is 0 has no effect, even if its data would clear a flag.
- R8: `irq_out` is 1 exactly when (flag0 and not mask0) or (flag1 and not mask1). Mask0 is byte 0x71 bit 4 and mask1 is bit 5.
- R9: A pulse on `blk_wr_en` loads `blk_wr_val[0]` into mask0 and `blk_wr_val[1]` into mask1.
- R10: When a channel line changes in the same cycle as a write-one-to-clear of that channel's flag, the flag takes the new line level.
- R11: A flag cleared by software stays 0 while its request line stays high. Only a later change of the line sets it again.
- R12: Flags, masks and `irq_out` all take their new values at the same clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq | input | 2 | Per-channel interrupt request levels |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W | Write byte address (low bits ignored, word aligned) |
| cfg_wr_data | input | 8*LANES | Write data, lane n carries byte n |
| cfg_wr_be | input | LANES | Write byte enables |
| cfg_rd_addr | input | ADDR_W | Read byte address (word aligned) |
| cfg_rd_data | output | 8*LANES | Read data, combinational |
| blk_wr_en | input | 1 | Mask-bit load strobe |
| blk_wr_val | input | 2 | Mask values for channels 0 and 1 |
| irq_out | output | 1 | Combined level interrupt |

## Verification
Two functions can act on the same flag in one cycle: a request line changing, and a configuration write that clears that flag. The bench provokes this by raising a channel line on the very edge that carries a clear to the flag, once through the mode byte and once through the status byte. It then reads both views, which must show the flag set, and checks that the interrupt line rose. It also holds a line high after a clear to confirm that a steady level does not re-set the flag.

// File: rtl/ism_pkg.sv
package ism_pkg;
  localparam int unsigned NCH        = 2;
  localparam int unsigned OFS_STAT0  = 'h50;
  localparam int unsigned OFS_ENABLE = 'h51;
  localparam int unsigned OFS_STAT1  = 'h57;
  localparam int unsigned OFS_MODE   = 'h71;
  localparam int unsigned POS_STAT0  = 2;
  localparam int unsigned POS_STAT1  = 4;
  localparam int unsigned POS_PEND   = 2;  // channel c at POS_PEND + c
  localparam int unsigned POS_MASK   = 4;  // channel c at POS_MASK + c
  localparam int unsigned POS_EN0    = 2;
  localparam int unsigned POS_EN1    = 3;

  typedef struct packed {
    logic [NCH-1:0] stat_clr;
    logic [NCH-1:0] mode_clr;
    logic           stat_hit;
    logic           mode_hit;
  } wr_req_t;
endpackage

// File: rtl/ism_wr_decode.sv
module ism_wr_decode
  import ism_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [8*LANES-1:0]   wr_data,
  input  logic [LANES-1:0]     wr_be,
  output wr_req_t              req
);
  localparam int unsigned LB = (LANES > 1) ? $clog2(LANES) : 0;

  logic [ADDR_W-1:0] base;
  wr_req_t           lane_req [LANES];

  assign base = (wr_addr >> LB) << LB;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] baddr;
    logic [7:0]        bdat;
    logic              act;
    assign baddr = base + ADDR_W'(l);
    assign bdat  = wr_data[8*l +: 8];
    assign act   = wr_en && wr_be[l];
    always_comb begin
      lane_req[l] = '0;
      if (act && baddr == ADDR_W'(OFS_STAT0)) begin
        lane_req[l].stat_hit    = 1'b1;
        lane_req[l].stat_clr[0] = bdat[POS_STAT0];
      end
      if (act && baddr == ADDR_W'(OFS_STAT1)) begin
        lane_req[l].stat_hit    = 1'b1;
        lane_req[l].stat_clr[1] = bdat[POS_STAT1];
      end
      if (act && baddr == ADDR_W'(OFS_MODE)) begin
        lane_req[l].mode_hit = 1'b1;
        lane_req[l].mode_clr = bdat[POS_PEND +: NCH];
      end
    end
  end

  always_comb begin
    req = '0;
    for (int l = 0; l < LANES; l++) begin
      req = req | lane_req[l];
    end
  end
endmodule

// File: rtl/ism_flag_core.sv
module ism_flag_core
  import ism_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  wr_req_t        req,
  input  logic [NCH-1:0] chan_lvl,
  input  logic           blk_we,
  input  logic [NCH-1:0] blk_val,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] pend_n,
  output logic [NCH-1:0] mask_n
);
  logic [NCH-1:0] chan_q;
  logic [NCH-1:0] chg;
  logic [NCH-1:0] stat_n;
  logic           state_en;

  assign chg      = chan_lvl ^ chan_q;
  assign state_en = req.stat_hit || req.mode_hit || (|chg) || blk_we;

  always_comb begin
    stat_n = stat_q & ~req.stat_clr;
    pend_n = pend_q & ~req.mode_clr;
    if (req.stat_hit) pend_n = stat_n;
    if (req.mode_hit) stat_n = pend_n;
    for (int c = 0; c < NCH; c++) begin
      if (chg[c]) begin
        pend_n[c] = chan_lvl[c];
        stat_n[c] = chan_lvl[c];
      end
    end
    mask_n = blk_we ? blk_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else begin
      chan_q <= chan_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else if (state_en) begin
      stat_q <= stat_n;
      pend_q <= pend_n;
      mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/ism_irq_gate.sv
module ism_irq_gate
  import ism_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_n,
  input  logic [NCH-1:0] mask_n,
  output logic           irq
);
  logic irq_n;

  assign irq_n = |(pend_n & ~mask_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_n;
    end
  end
endmodule

// File: rtl/irq_status_mirror.sv
module irq_status_mirror
  import ism_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned LANES        = 4,
  parameter bit          SECONDARY_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          chan_irq,
  input  logic                cfg_wr_en,
  input  logic [ADDR_W-1:0]   cfg_wr_addr,
  input  logic [8*LANES-1:0]  cfg_wr_data,
  input  logic [LANES-1:0]    cfg_wr_be,
  input  logic [ADDR_W-1:0]   cfg_rd_addr,
  output logic [8*LANES-1:0]  cfg_rd_data,
  input  logic                blk_wr_en,
  input  logic [1:0]          blk_wr_val,
  output logic                irq_out
);
  localparam int unsigned LB       = (LANES > 1) ? $clog2(LANES) : 0;
  localparam logic [7:0]  EN_BYTE  = 8'((1 << POS_EN0) | (SECONDARY_EN ? (1 << POS_EN1) : 0));

  wr_req_t        req;
  logic [NCH-1:0] stat_q, pend_q, mask_q, pend_n, mask_n;
  logic [ADDR_W-1:0] rd_base;

  ism_wr_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .wr_be   (cfg_wr_be),
    .req     (req)
  );

  ism_flag_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .chan_lvl (chan_irq),
    .blk_we   (blk_wr_en),
    .blk_val  (blk_wr_val),
    .stat_q   (stat_q),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .pend_n   (pend_n),
    .mask_n   (mask_n)
  );

  ism_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_n (pend_n),
    .mask_n (mask_n),
    .irq    (irq_out)
  );

  assign rd_base = (cfg_rd_addr >> LB) << LB;

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    logic [ADDR_W-1:0] baddr;
    assign baddr = rd_base + ADDR_W'(l);
    always_comb begin
      cfg_rd_data[8*l +: 8] = 8'h00;
      if (baddr == ADDR_W'(OFS_STAT0)) cfg_rd_data[8*l + POS_STAT0] = stat_q[0];
      if (baddr == ADDR_W'(OFS_STAT1)) cfg_rd_data[8*l + POS_STAT1] = stat_q[1];
      if (baddr == ADDR_W'(OFS_ENABLE)) cfg_rd_data[8*l +: 8] = EN_BYTE;
      if (baddr == ADDR_W'(OFS_MODE)) begin
        cfg_rd_data[8*l + POS_PEND +: NCH] = pend_q;
        cfg_rd_data[8*l + POS_MASK +: NCH] = mask_q;
      end
    end
  end
endmodule

// File: rtl/ism_checker.sv
module ism_checker
  import ism_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          chan_irq,
  input logic                cfg_wr_en,
  input logic [ADDR_W-1:0]   cfg_wr_addr,
  input logic [8*LANES-1:0]  cfg_wr_data,
  input logic [LANES-1:0]    cfg_wr_be,
  input logic                blk_wr_en,
  input logic [1:0]          blk_wr_val,
  input logic [1:0]          stat_q,
  input logic [1:0]          pend_q,
  input logic [1:0]          mask_q,
  input logic                irq_out
);
  localparam int unsigned LB        = (LANES > 1) ? $clog2(LANES) : 0;
  localparam int unsigned MODE_LANE = OFS_MODE % LANES;
  localparam int unsigned MODE_BASE = OFS_MODE - MODE_LANE;

  logic [ADDR_W-1:0] wr_base;
  logic              mode_clr0;
  assign wr_base   = (cfg_wr_addr >> LB) << LB;
  assign mode_clr0 = cfg_wr_en && wr_base == ADDR_W'(MODE_BASE) && cfg_wr_be[MODE_LANE]
                     && cfg_wr_data[8*MODE_LANE + POS_PEND];

  // R3: both views of every flag agree
  p_views_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == pend_q);

  // R4: a clear through the mode byte with the line low leaves the flag 0
  p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_clr0 && !chan_irq[0]) |=> !pend_q[0]);

  // R6: masks only move through the mask port
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_wr_en |=> $stable(mask_q));

  // R8: output equals unmasked pending
  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(pend_q & ~mask_q));

  // R9: mask port loads both bits
  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr_en |=> mask_q == $past(blk_wr_val));

  // R10: a rising line always leaves the flag set
  p_line_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_irq[0]) |=> pend_q[0]);
endmodule

bind irq_status_mirror ism_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_irq    (chan_irq),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_addr (cfg_wr_addr),
  .cfg_wr_data (cfg_wr_data),
  .cfg_wr_be   (cfg_wr_be),
  .blk_wr_en   (blk_wr_en),
  .blk_wr_val  (blk_wr_val),
  .stat_q      (stat_q),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .irq_out     (irq_out)
);

// File: tb/irq_status_mirror_test.sv
`timescale 1ns/100ps
module irq_status_mirror_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_irq = 2'b00;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = 8'h00;
  logic [31:0] cfg_wr_data = 32'h0;
  logic [3:0]  cfg_wr_be = 4'h0;
  logic [7:0]  cfg_rd_addr = 8'h00;
  logic [31:0] cfg_rd_data;
  logic        blk_wr_en = 1'b0;
  logic [1:0]  blk_wr_val = 2'b00;
  logic        irq_out;

  irq_status_mirror uut (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_be(cfg_wr_be), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .blk_wr_en(blk_wr_en), .blk_wr_val(blk_wr_val), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          applied = 0;
  int          miscmp = 0;
  bit          done = 1'b0;
  logic [1:0]  mp = 2'b00;  // model flags
  logic [1:0]  mb = 2'b00;  // model masks

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a)
      8'h50:   return {16'h0, 8'h0C, 5'b0, mp[0], 2'b0};
      8'h54:   return {3'b0, mp[1], 28'h0};
      8'h70:   return {16'h0, 2'b0, mb, mp, 2'b0, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [1:0] ch,
                       input bit bw, input logic [1:0] bv);
    @(negedge clk);
    cfg_wr_en = wr; cfg_wr_addr = a; cfg_wr_data = d; cfg_wr_be = be;
    chan_irq = ch; blk_wr_en = bw; blk_wr_val = bv;
    @(negedge clk);
    cfg_wr_en = 1'b0; blk_wr_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_rd_addr = a;
    e.addr = a; e.data = model_rd(a); e.irq = |(mp & ~mb); e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        applied++;
        if (cfg_rd_data !== e.data || irq_out !== e.irq) begin
          miscmp++;
          $display("FAIL %s addr=%h actual data=%h irq=%b expected data=%h irq=%b",
                   e.tag, e.addr, cfg_rd_data, irq_out, e.data, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: reset state
    chk(8'h50, "R1 R2 reset 0x50");
    chk(8'h54, "R1 reset 0x54");
    chk(8'h70, "R1 reset 0x70");
    // R3 R8 R12: channel 0 rises
    drive(0, 8'h00, 0, 4'h0, 2'b01, 0, 2'b00); mp[0] = 1;
    chk(8'h70, "R3 R8 R12 ch0 mode view");
    chk(8'h50, "R3 ch0 status view");
    // R3: channel 1 rises
    drive(0, 8'h00, 0, 4'h0, 2'b11, 0, 2'b00); mp[1] = 1;
    chk(8'h54, "R3 ch1 status view");
    chk(8'h70, "R3 ch1 mode view");
    // R9 R8: masks
    drive(0, 8'h00, 0, 4'h0, 2'b11, 1, 2'b01); mb = 2'b01;
    chk(8'h70, "R9 R8 mask ch0");
    drive(0, 8'h00, 0, 4'h0, 2'b11, 1, 2'b11); mb = 2'b11;
    chk(8'h70, "R8 both masked irq low");
    drive(0, 8'h00, 0, 4'h0, 2'b11, 1, 2'b10); mb = 2'b10;
    chk(8'h70, "R9 R8 mask ch1 only");
    // R6: mask and enable bits not writable by config, zeros do not clear
    drive(1, 8'h70, 32'h0000_3000, 4'hF, 2'b11, 0, 2'b00);
    chk(8'h70, "R6 mask bits hold");
    drive(1, 8'h50, 32'hFFFF_F3FB, 4'hF, 2'b11, 0, 2'b00);
    chk(8'h50, "R6 R2 enable byte hold");
    // R7: disabled lane ignored
    drive(1, 8'h70, 32'h0000_0400, 4'b1101, 2'b11, 0, 2'b00);
    chk(8'h70, "R7 disabled lane");
    drive(1, 8'h50, 32'h0000_0004, 4'b1110, 2'b11, 0, 2'b00);
    chk(8'h50, "R7 disabled status lane");
    // R4: clear ch0 via mode byte
    drive(1, 8'h70, 32'h0000_0400, 4'hF, 2'b11, 0, 2'b00); mp[0] = 0;
    chk(8'h70, "R4 mode clear");
    chk(8'h50, "R4 status view follows");
    // R11: line still high, flag stays clear
    repeat (4) @(negedge clk);
    chk(8'h70, "R11 steady high no reset");
    // R5: clear ch1 via status byte 0x57
    drive(1, 8'h54, 32'h1000_0000, 4'hF, 2'b11, 0, 2'b00); mp[1] = 0;
    chk(8'h70, "R5 status clear ch1");
    chk(8'h54, "R5 status view ch1");
    // R3: lines fall then ch0 rises and falls
    drive(0, 8'h00, 0, 4'h0, 2'b00, 1, 2'b00); mb = 2'b00;
    chk(8'h70, "R3 falls no change");
    drive(0, 8'h00, 0, 4'h0, 2'b01, 0, 2'b00); mp[0] = 1;
    chk(8'h50, "R3 ch0 rise again");
    drive(0, 8'h00, 0, 4'h0, 2'b00, 0, 2'b00); mp[0] = 0;
    chk(8'h70, "R3 ch0 fall clears");
    // R10: rise together with clear, via mode byte
    drive(1, 8'h70, 32'h0000_0400, 4'hF, 2'b01, 0, 2'b00); mp[0] = 1;
    chk(8'h70, "R10 ch0 line wins");
    chk(8'h50, "R10 ch0 status view");
    // R10: rise together with clear, via status byte
    drive(1, 8'h54, 32'h1000_0000, 4'hF, 2'b11, 0, 2'b00); mp[1] = 1;
    chk(8'h54, "R10 ch1 line wins");
    chk(8'h70, "R10 R8 ch1 mode view");
    // R5: clear ch0 via status byte 0x50
    drive(1, 8'h50, 32'h0000_0004, 4'h1, 2'b11, 0, 2'b00); mp[0] = 0;
    chk(8'h70, "R5 status clear ch0");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule